// File: doc/BRIEF.md
# Iterative Integer Divider with Condition Flags

This block performs integer division for a 32-bit processor core. The core presents the operands together with a signedness select, an operand-shape select and a one-cycle start pulse. The block then runs a shift-and-subtract loop that produces one quotient bit per clock. When it finishes, it raises a one-cycle completion pulse that carries the quotient and remainder, write strobes for the two destination registers and the four condition flags. A zero divisor is caught when the operation is issued. In that case the block raises a trap pulse and writes nothing.

Three operand shapes are supported, selected by `size`:
- `00`: a 32-bit dividend over a 16-bit divisor, giving a packed 16-bit result.
- `01` (and `11`): a 32-bit dividend over a 32-bit divisor, giving a separate quotient and remainder.
- `10`: a 64-bit dividend over a 32-bit divisor.

The register file, the register read ports and the trap handler sit outside the block. The core passes the two destination indices in so that the block can resolve the aliasing rule for the long form.

Top module: `int_divider`

## Requirements
- R1: A zero divisor raises `dz_trap` and `done` in the cycle after `start`, with both write strobes low and all four flags unchanged. The divisor is `divisor[15:0]` for size `00` and `divisor[31:0]` otherwise.
- R2: Every division that completes without a trap leaves `flag_c` at 0.
- R3: In size `00`, an unsigned quotient above 0xFFFF is an overflow. A signed quotient outside -32768..32767 is also an overflow.
- R4: On overflow, `flag_v`=1 and `flag_z`=1, `flag_n` keeps its previous value, and neither write strobe is raised.
- R5: In size `00`, a valid result raises only `wr_quo`, with `quotient[31:16]` holding the remainder and `quotient[15:0]` holding the quotient. `flag_n` is quotient bit 15, and `flag_z` is set when the 16-bit quotient is zero.
- R6: In size `10`, the dividend is `{dividend_hi, dividend_lo}`. An overflow is a quotient that does not fit in 32 bits: unsigned, or two's complement when signed.
- R7: When `q_idx` equals `r_idx` in sizes `01`/`10`, only `wr_quo` is raised. When the indices differ and `reduced_alias`=1 in size `01`, only `wr_rem` is raised. When the indices differ in any other case, both strobes are raised.
- R8: A signed quotient truncates toward zero, and the remainder takes the sign of the dividend. In sizes `01`/`10`, `flag_n` is quotient bit 31, `flag_z` is set when the 32-bit quotient is zero, and `flag_v`=0.
- R9: `done` is a single-cycle pulse, and `busy` is high while a division is in progress. A `start` pulse while `busy` is high is ignored.
- R10: Size `01` never overflows. The case -2^31 / -1 signed wraps to quotient 0x80000000 with remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue a division (single-cycle pulse) |
| is_signed | input | 1 | 1 = two's complement operands |
| size | input | 2 | 00 word, 01/11 long, 10 quad |
| reduced_alias | input | 1 | Selects the single-write rule for the long form |
| q_idx | input | 3 | Quotient destination register index |
| r_idx | input | 3 | Remainder destination register index |
| dividend_hi | input | 32 | Upper dividend half (size 10 only) |
| dividend_lo | input | 32 | Lower dividend half |
| divisor | input | 32 | Divisor (low 16 bits used in size 00) |
| busy | output | 1 | Division in progress |
| done | output | 1 | Result, strobes and flags valid (one cycle) |
| dz_trap | output | 1 | Divide-by-zero trap (one cycle, with done) |
| quotient | output | 32 | Quotient, or the packed word result |
| remainder | output | 32 | Remainder |
| wr_quo | output | 1 | Write the quotient register |
| wr_rem | output | 1 | Write the remainder register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The hardest situations to reach from the ports are the boundaries of the overflow tests. These are quotients that land exactly on -32768 or -2^31, or one step past them, and they sit next to the sign-magnitude correction. The stimulus builds these from chosen operand pairs: -65536/2 against 65536/2 in the word shape, and -2^32 over 2 and over -2 in the quad shape. A second situation that is hard to reach is a start pulse that arrives in the middle of an iteration. The bench issues one deliberately while `busy` is high. The scoreboard then flags any extra completion as an item that arrived with no expectation queued.

// File: rtl/int_divider.sv
module int_divider #(
  parameter int W    = 32,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_signed,
  input  logic [1:0]      size,
  input  logic            reduced_alias,
  input  logic [IDXW-1:0] q_idx,
  input  logic [IDXW-1:0] r_idx,
  input  logic [W-1:0]    dividend_hi,
  input  logic [W-1:0]    dividend_lo,
  input  logic [W-1:0]    divisor,
  output logic            busy,
  output logic            done,
  output logic            dz_trap,
  output logic [W-1:0]    quotient,
  output logic [W-1:0]    remainder,
  output logic            wr_quo,
  output logic            wr_rem,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_v,
  output logic            flag_c
);
  localparam int DW = 2 * W;
  localparam int HW = W / 2;
  localparam int CW = $clog2(DW + 1);
  localparam logic [DW-1:0] LIM_H = DW'(1) << (HW - 1);
  localparam logic [DW-1:0] LIM_W = DW'(1) << (W - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t st;

  wire in_word = (size == 2'b00);
  wire in_quad = (size == 2'b10);

  wire [W-1:0] den_raw = in_word ? {{HW{is_signed & divisor[HW-1]}}, divisor[HW-1:0]} : divisor;
  wire den_neg = is_signed & den_raw[W-1];
  wire [W-1:0] den_mag = den_neg ? -den_raw : den_raw;
  wire den_zero = (den_raw == '0);

  wire [DW-1:0] num_raw = in_quad ? {dividend_hi, dividend_lo}
                                  : {{W{is_signed & dividend_lo[W-1]}}, dividend_lo};
  wire num_neg = is_signed & num_raw[DW-1];
  wire [DW-1:0] num_mag = num_neg ? -num_raw : num_raw;

  logic [DW-1:0]   quo;
  logic [W-1:0]    rem;
  logic [W-1:0]    dm;
  logic [CW-1:0]   cnt;
  logic            qneg, rneg, sgn_r, alias_r, red_r;
  logic [1:0]      mode_r;

  wire [W:0] sh   = {rem, quo[DW-1]};
  wire [W:0] diff = sh - {1'b0, dm};
  wire       ge   = ~diff[W];

  wire m_word = (mode_r == 2'b00);
  wire m_quad = (mode_r == 2'b10);
  wire m_long = !m_word && !m_quad;

  wire [DW-1:0] q_s = qneg ? -quo : quo;
  wire [W-1:0]  r_s = rneg ? -rem : rem;

  wire ovf_word = sgn_r ? (qneg ? (quo > LIM_H) : (quo >= LIM_H)) : (|quo[DW-1:HW]);
  wire ovf_quad = sgn_r ? (qneg ? (quo > LIM_W) : (quo >= LIM_W)) : (|quo[DW-1:W]);
  wire ovf = m_word ? ovf_word : (m_quad ? ovf_quad : 1'b0);

  wire res_n = m_word ? q_s[HW-1] : q_s[W-1];
  wire res_z = m_word ? (q_s[HW-1:0] == '0) : (q_s[W-1:0] == '0);

  wire fin_wq = !ovf && (m_word || alias_r || !(red_r && m_long));
  wire fin_wr = !ovf && !m_word && !alias_r;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      quo <= '0; rem <= '0; dm <= '0; cnt <= '0;
      qneg <= 1'b0; rneg <= 1'b0; sgn_r <= 1'b0; alias_r <= 1'b0; red_r <= 1'b0;
      mode_r <= 2'b00;
      done <= 1'b0; dz_trap <= 1'b0; wr_quo <= 1'b0; wr_rem <= 1'b0;
      quotient <= '0; remainder <= '0;
      flag_n <= 1'b0; flag_z <= 1'b0; flag_v <= 1'b0; flag_c <= 1'b0;
    end else begin
      done <= 1'b0; dz_trap <= 1'b0; wr_quo <= 1'b0; wr_rem <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (den_zero) begin
            done <= 1'b1;
            dz_trap <= 1'b1;
          end else begin
            quo     <= in_quad ? num_mag : {num_mag[W-1:0], {W{1'b0}}};
            rem     <= '0;
            dm      <= den_mag;
            cnt     <= in_quad ? CW'(DW) : CW'(W);
            qneg    <= num_neg ^ den_neg;
            rneg    <= num_neg;
            sgn_r   <= is_signed;
            mode_r  <= size;
            alias_r <= (q_idx == r_idx);
            red_r   <= reduced_alias;
            st      <= S_RUN;
          end
        end
        S_RUN: begin
          rem <= ge ? diff[W-1:0] : sh[W-1:0];
          quo <= {quo[DW-2:0], ge};
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= S_FIN;
        end
        S_FIN: begin
          st <= S_IDLE;
          done <= 1'b1;
          quotient  <= m_word ? {r_s[HW-1:0], q_s[HW-1:0]} : q_s[W-1:0];
          remainder <= r_s;
          wr_quo <= fin_wq;
          wr_rem <= fin_wr;
          flag_c <= 1'b0;
          if (ovf) begin
            flag_v <= 1'b1;
            flag_z <= 1'b1;
          end else begin
            flag_v <= 1'b0;
            flag_z <= res_z;
            flag_n <= res_n;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_nowrite_dz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dz_trap |-> done && !wr_quo && !wr_rem);
  p_flags_hold_dz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dz_trap |-> $stable({flag_n, flag_z, flag_v, flag_c}));
  p_carry_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dz_trap) |-> !flag_c);
  p_no_overflow_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dz_trap && flag_v) |-> flag_z && !wr_quo && !wr_rem);
  p_overflow_keeps_n_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dz_trap && flag_v) |-> $stable(flag_n));
  p_word_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dz_trap && m_word) |-> !wr_rem);
  p_alias_single_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_quo && wr_rem) |-> !alias_r);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dz_trap) |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_long_no_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dz_trap && m_long) |-> !flag_v);
endmodule

// File: tb/int_divider_test.sv
module int_divider_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, is_signed = 1'b0, reduced_alias = 1'b0;
  logic [1:0] size = 2'b00;
  logic [2:0] q_idx = 3'd0, r_idx = 3'd1;
  logic [31:0] dividend_hi = '0, dividend_lo = '0, divisor = '0;
  logic busy, done, dz_trap, wr_quo, wr_rem, flag_n, flag_z, flag_v, flag_c;
  logic [31:0] quotient, remainder;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_divider uut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed), .size(size),
    .reduced_alias(reduced_alias), .q_idx(q_idx), .r_idx(r_idx),
    .dividend_hi(dividend_hi), .dividend_lo(dividend_lo), .divisor(divisor),
    .busy(busy), .done(done), .dz_trap(dz_trap), .quotient(quotient),
    .remainder(remainder), .wr_quo(wr_quo), .wr_rem(wr_rem),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  typedef struct {
    logic dz, wq, wr, n, z, v, c;
    logic [31:0] q, r;
    string tag;
  } exp_t;

  exp_t sb[$];
  logic mn = 0, mz = 0, mv = 0, mc = 0;

  task automatic issue(input logic [1:0] sz, input logic sgn, input logic red,
                       input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] dv,
                       input logic [2:0] qi, input logic [2:0] ri, input string tag);
    exp_t e;
    logic [63:0] n, d, q, r;
    logic signed [63:0] qs;
    logic ov;
    if (sz == 2'b00) begin
      d = sgn ? {{48{dv[15]}}, dv[15:0]} : {48'b0, dv[15:0]};
      n = sgn ? {{32{lo[31]}}, lo} : {32'b0, lo};
    end else begin
      d = sgn ? {{32{dv[31]}}, dv} : {32'b0, dv};
      n = (sz == 2'b10) ? {hi, lo} : (sgn ? {{32{lo[31]}}, lo} : {32'b0, lo});
    end
    e.dz = (d == 0);
    q = 0; r = 0;
    if (!e.dz) begin
      if (sgn) begin
        q = $signed(n) / $signed(d);
        r = $signed(n) % $signed(d);
      end else begin
        q = n / d;
        r = n % d;
      end
    end
    qs = q;
    ov = 1'b0;
    if (sz == 2'b00) ov = sgn ? (qs > 64'sd32767 || qs < -64'sd32768) : (q > 64'hFFFF);
    if (sz == 2'b10) ov = sgn ? (qs > 64'sd2147483647 || qs < -64'sd2147483648) : (q > 64'hFFFF_FFFF);
    e.q = (sz == 2'b00) ? {r[15:0], q[15:0]} : q[31:0];
    e.r = r[31:0];
    e.wq = 0; e.wr = 0;
    if (!e.dz) begin
      mc = 0;
      if (ov) begin
        mv = 1; mz = 1;
      end else begin
        mv = 0;
        mn = (sz == 2'b00) ? q[15] : q[31];
        mz = (sz == 2'b00) ? (q[15:0] == 0) : (q[31:0] == 0);
        if (sz == 2'b00) e.wq = 1;
        else if (qi == ri) e.wq = 1;
        else if (red && sz != 2'b10) e.wr = 1;
        else begin e.wq = 1; e.wr = 1; end
      end
    end
    e.n = mn; e.z = mz; e.v = mv; e.c = mc;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    size = sz; is_signed = sgn; reduced_alias = red;
    dividend_hi = hi; dividend_lo = lo; divisor = dv; q_idx = qi; r_idx = ri;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R9: unexpected done, actual done=1 expected done=0");
      end else begin
        exp_t e;
        logic bad;
        e = sb.pop_front();
        bad = (dz_trap !== e.dz) || (wr_quo !== e.wq) || (wr_rem !== e.wr) ||
              ({flag_n, flag_z, flag_v, flag_c} !== {e.n, e.z, e.v, e.c}) ||
              (e.wq && quotient !== e.q) || (e.wr && remainder !== e.r);
        if (bad) begin
          fails++;
          $display("FAIL %s: actual dz=%b wq=%b wr=%b nzvc=%b%b%b%b q=%h r=%h expected dz=%b wq=%b wr=%b nzvc=%b%b%b%b q=%h r=%h",
                   e.tag, dz_trap, wr_quo, wr_rem, flag_n, flag_z, flag_v, flag_c, quotient, remainder,
                   e.dz, e.wq, e.wr, e.n, e.z, e.v, e.c, e.q, e.r);
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (busy !== 0 || done !== 0 || dz_trap !== 0 || wr_quo !== 0 || wr_rem !== 0 ||
        {flag_n, flag_z, flag_v, flag_c} !== 4'b0) begin
      fails++;
      $display("FAIL R9: reset state actual busy=%b done=%b nzvc=%b%b%b%b expected all 0",
               busy, done, flag_n, flag_z, flag_v, flag_c);
    end
    rst_n = 1'b1;
    // R5 word shape, unsigned and signed packing
    issue(2'b00, 0, 0, 0, 32'd100000, 32'd7, 0, 1, "R5");
    issue(2'b00, 1, 0, 0, -32'sd100, 32'd7, 0, 1, "R8_R5");
    issue(2'b00, 1, 0, 0, 32'd5, 32'h0000_FFFF, 0, 1, "R5");
    // R3 R4 word overflow boundaries
    issue(2'b00, 0, 0, 0, 32'h0002_0000, 32'd1, 0, 1, "R3_R4");
    issue(2'b00, 1, 0, 0, -32'sd65536, 32'd2, 0, 1, "R3");
    issue(2'b00, 1, 0, 0, 32'd65536, 32'd2, 0, 1, "R3_R4");
    // R1 zero divisor, word ignores upper divisor bits
    issue(2'b00, 0, 0, 0, 32'd1234, 32'h0001_0000, 0, 1, "R1");
    issue(2'b01, 1, 0, 0, 32'd99, 32'd0, 0, 1, "R1");
    // R7 write rules in long form
    issue(2'b01, 0, 0, 0, 32'hFFFF_FFFF, 32'h10, 2, 3, "R7");
    issue(2'b01, 0, 1, 0, 32'd1000, 32'd7, 2, 3, "R7");
    issue(2'b01, 0, 1, 0, 32'd1000, 32'd7, 4, 4, "R7");
    issue(2'b01, 0, 0, 0, 32'd1000, 32'd7, 5, 5, "R7");
    issue(2'b11, 1, 0, 0, -32'sd1000, 32'd7, 1, 2, "R8");
    issue(2'b01, 0, 0, 0, 32'd5, 32'd7, 1, 2, "R8_R2");
    // R10 wrap
    issue(2'b01, 1, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 1, 2, "R10");
    // R6 quad shape
    issue(2'b10, 0, 1, 32'd1, 32'd0, 32'd2, 1, 2, "R6");
    issue(2'b10, 0, 0, 32'd2, 32'd0, 32'd2, 1, 2, "R6_R4");
    issue(2'b10, 1, 0, 32'hFFFF_FFFF, 32'd0, 32'd2, 1, 2, "R6");
    issue(2'b10, 1, 0, 32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFE, 1, 2, "R6_R4");
    issue(2'b10, 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FF00, 32'd7, 1, 2, "R8");
    issue(2'b10, 0, 0, 32'd5, 32'd5, 32'd0, 1, 2, "R1");
    // R9 start during busy is ignored
    begin
      exp_t e;
      e.dz = 0; e.wq = 1; e.wr = 1; e.q = 32'd100; e.r = 32'd0;
      e.n = 0; e.z = 0; e.v = 0; e.c = 0; e.tag = "R9";
      mn = 0; mz = 0; mv = 0; mc = 0;
      sb.push_back(e);
      @(negedge clk);
      size = 2'b01; is_signed = 0; reduced_alias = 0; q_idx = 1; r_idx = 2;
      dividend_lo = 32'd300; divisor = 32'd3; start = 1;
      @(negedge clk); start = 0;
      repeat (5) @(negedge clk);
      dividend_lo = 32'd7; divisor = 32'd0; start = 1;
      @(negedge clk); start = 0;
      while (!done) @(negedge clk);
      repeat (40) @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
        fails++;
        $display("FAIL R9: pending items actual %0d expected 0", sb.size());
      end
    end
    finish_run();
  end
endmodule